// File: doc/BRIEF.md
# Frame-Synchronous Byte Scrambler

This block applies an additive keystream to a byte stream that is organised in rows and columns, one byte per clock. Every accepted byte carries a frame-start strobe and its row and column position. The block XORs the byte with eight consecutive bits from a 7-stage linear feedback shift register. The register is forced back to all ones whenever a frame begins, so the keystream lines up with frame boundaries. Transmit and receive sides therefore stay in step without any shared state.

A small window of overhead bytes at the top of each frame is sent through unchanged and does not consume keystream. Additive scrambling is its own inverse. On the receive side the same block descrambles bytes that an upstream frame detector has already aligned.

Both data sides use a valid/ready handshake. A byte is accepted on a rising edge where `s_valid` and `s_ready` are both high. The result sits in a single output register. When the output register holds a byte that has not been taken, `s_ready` drops and no new byte is accepted. When the register is empty, or its byte is being taken in the same cycle, `s_ready` is high. Data, strobe and position must stay stable while `s_valid` is high and `s_ready` is low.

Top module: `frame_scrambler`

## Requirements
- R1: A byte accepted on one rising edge appears on `m_data` with `m_valid` high right after that edge, a fixed latency of one cycle.
- R2: `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_sof` hold their values.
- R3: The keystream comes from a 7-stage register with generator x^7+x^6+1. Each step outputs the oldest stage, so the sequence from the all-ones seed is o[0..6]=1 and o[n+7]=o[n] xor o[n+1]. Within a scrambled byte, the first bit of the eight goes to bit 7 and the last goes to bit 0.
- R4: An accepted byte with `s_sof`=1 reseeds the register to all ones before that byte is processed. This applies at any position, including a position that is scrambled.
- R5: An accepted byte in row 0 with column 0 to 8 passes through unchanged and consumes no keystream. Column 9 of row 0, and every column of any other row, is scrambled.
- R6: The keystream advances by eight bits only on an accepted scrambled byte. Idle cycles and stalled cycles leave it unchanged.
- R7: Passing the scrambled output through the block again, with the same frame start and positions, restores the original bytes.
- R8: `m_sof` carries the `s_sof` value of the byte shown on `m_data`.
- R9: After reset, `m_valid` is 0 and the register holds all ones. The first scrambled byte then uses o[0..7], even if no frame start came first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block can accept a byte this cycle |
| s_data | input | 8 | Input byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_row | input | 4 | Row index of the byte |
| s_col | input | 9 | Column index of the byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream takes the output byte |
| m_data | output | 8 | Scrambled or passed byte |
| m_sof | output | 1 | Frame-start flag aligned with m_data |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle handoff;
- output stability under back-pressure;
- that clear-window bytes come out unchanged;
- that the frame strobe follows its byte;
- that the register reseeds on a frame start and stays still otherwise;
- that the register never reaches the all-zero lock-up state.

Only the bench scenarios can show that the keystream bits are the right ones and land in the right bit order. The same holds for the exact boundary at column 9 and for reseeding at a scrambled position. Round-trip restoration of the data also needs the bench, which compares against a sequence it builds from the recurrence, over all 256 byte values and across idle and stalled gaps.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {
    KIND_CLEAR  = 1'b0,
    KIND_MASKED = 1'b1
  } beat_kind_e;
endpackage

// File: rtl/scr_window.sv
module scr_window #(
  parameter int ROW_W      = 4,
  parameter int COL_W      = 9,
  parameter int CLEAR_ROW  = 0,
  parameter int CLEAR_COLS = 9
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output scr_pkg::beat_kind_e kind
);
  localparam logic [ROW_W-1:0] ROW_K = ROW_W'(CLEAR_ROW);
  localparam logic [COL_W-1:0] COL_K = COL_W'(CLEAR_COLS);

  always_comb begin
    if (row == ROW_K && col < COL_K) kind = scr_pkg::KIND_CLEAR;
    else                             kind = scr_pkg::KIND_MASKED;
  end
endmodule

// File: rtl/scr_keystream.sv
module scr_keystream #(
  parameter int LEN   = 7,
  parameter int TAP_A = 7,
  parameter int TAP_B = 6,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [OUT_W-1:0] ks
);
  localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

  logic [LEN-1:0] state;
  logic [LEN-1:0] chain [OUT_W+1];

  assign chain[0] = restart ? SEED : state;

  for (genvar i = 0; i < OUT_W; i++) begin : g_step
    assign ks[OUT_W-1-i] = chain[i][LEN-1];
    assign chain[i+1]    = {chain[i][LEN-2:0], chain[i][TAP_A-1] ^ chain[i][TAP_B-1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= SEED;
    else if (step)    state <= chain[OUT_W];
    else if (restart) state <= SEED;
  end

  a_r4_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !step) |=> (state == SEED));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !step) |=> $stable(state));
  always_ff @(posedge clk) begin
    if (rst_n) a_r3_no_lockup: assert (state != '0);
  end
endmodule

// File: rtl/scr_outreg.sv
module scr_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_in,
  input  logic              sof_in,
  output logic              ready,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_sof
);
  assign ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_sof   <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= d_in;
      m_sof   <= sof_in;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> m_valid);
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sof)));
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler #(
  parameter int DATA_W     = 8,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 9,
  parameter int LFSR_LEN   = 7,
  parameter int TAP_A      = 7,
  parameter int TAP_B      = 6,
  parameter int CLEAR_ROW  = 0,
  parameter int CLEAR_COLS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_sof,
  input  logic [ROW_W-1:0]  s_row,
  input  logic [COL_W-1:0]  s_col,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_sof
);
  scr_pkg::beat_kind_e kind;
  logic                accept;
  logic [DATA_W-1:0]   ks;
  logic [DATA_W-1:0]   mixed;

  assign accept = s_valid && s_ready;

  scr_window #(
    .ROW_W(ROW_W), .COL_W(COL_W),
    .CLEAR_ROW(CLEAR_ROW), .CLEAR_COLS(CLEAR_COLS)
  ) u_window (
    .row(s_row), .col(s_col), .kind(kind)
  );

  scr_keystream #(
    .LEN(LFSR_LEN), .TAP_A(TAP_A), .TAP_B(TAP_B), .OUT_W(DATA_W)
  ) u_keys (
    .clk(clk), .rst_n(rst_n),
    .restart(accept && s_sof),
    .step(accept && kind == scr_pkg::KIND_MASKED),
    .ks(ks)
  );

  assign mixed = (kind == scr_pkg::KIND_MASKED) ? (s_data ^ ks) : s_data;

  scr_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .d_in(mixed), .sof_in(s_sof),
    .ready(s_ready),
    .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_sof(m_sof)
  );

  a_r5_clear_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == scr_pkg::KIND_CLEAR) |=> (m_data == $past(s_data)));
  a_r8_sof_follow: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (m_sof == $past(s_sof)));
endmodule

// File: tb/frame_scrambler_bench.sv
module frame_scrambler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 127;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       s_sof = 1'b0;
  logic [3:0] s_row = '0;
  logic [8:0] s_col = '0;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [7:0] m_data;
  logic       m_sof;

  int checks = 0;
  int errors = 0;
  int ptr = 0;
  bit ks_bits [PERIOD];
  logic [7:0] last_out;
  logic [7:0] orig [12];
  logic [7:0] scr  [12];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_scrambler u_frame_scrambler (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_row(s_row), .s_col(s_col),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] key_at(input int p);
    logic [7:0] k;
    for (int b = 0; b < 8; b++) k[7-b] = ks_bits[(p + b) % PERIOD];
    return k;
  endfunction

  // model of R3/R4/R5/R6: returns expected output, updates ptr
  function automatic logic [7:0] model(input logic [7:0] d, input logic sof,
                                       input int row, input int col);
    logic [7:0] e;
    if (sof) ptr = 0;
    if (row == 0 && col < 9) e = d;
    else begin
      e = d ^ key_at(ptr);
      ptr = (ptr + 8) % PERIOD;
    end
    return e;
  endfunction

  // drive one byte at a negedge, check at the following negedge (R1, R8)
  task automatic send(input logic [7:0] d, input logic sof, input int row,
                      input int col, input string req);
    logic [7:0] e;
    e = model(d, sof, row, col);
    s_valid = 1'b1; s_data = d; s_sof = sof;
    s_row = 4'(row); s_col = 9'(col);
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0;
    chk({req, " R1 valid"}, {8'h0, m_valid}, 9'h1);
    chk({req, " data"}, {1'b0, m_data}, {1'b0, e});
    chk({req, " R8 sof"}, {8'h0, m_sof}, {8'h0, sof});
    last_out = m_data;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] ex, ey;
    for (int i = 0; i < 7; i++) ks_bits[i] = 1'b1;
    for (int i = 7; i < PERIOD; i++) ks_bits[i] = ks_bits[i-7] ^ ks_bits[i-6];

    repeat (3) @(negedge clk);
    chk("R9 reset valid", {8'h0, m_valid}, 9'h0);
    chk("R2 ready empty", {8'h0, s_ready}, 9'h1);
    rst_n = 1'b1;

    // R9: seed used without any frame start
    send(8'h00, 1'b0, 5, 0, "R9 seed");
    chk("R9 seed is 0xFE", {1'b0, last_out}, 9'h0FE);

    // R5 window and its boundary, then R3 stream
    for (int c = 0; c < 12; c++) send(8'(c * 17 + 3), c == 0, 0, c, "R5 row0");
    for (int c = 0; c < 4; c++) send(8'hA5, 1'b0, 1, c, "R3 row1");

    // R6 idle gap leaves keystream untouched
    repeat (2) @(negedge clk);
    chk("R6 idle drained", {8'h0, m_valid}, 9'h0);
    for (int c = 4; c < 8; c++) send(8'h3C, 1'b0, 1, c, "R6 after idle");

    // R4 reseed at a scrambled position
    send(8'h00, 1'b1, 2, 5, "R4 mid reseed");
    chk("R4 fresh key", {1'b0, last_out}, 9'h0FE);

    // all 256 byte values, across keystream wrap
    send(8'h00, 1'b1, 0, 0, "R5 frame start");
    for (int v = 0; v < 256; v++) send(8'(v), 1'b0, 3, v, "R3 sweep");

    // R2 back-pressure: stall with a pending byte
    @(negedge clk);
    m_ready = 1'b0;
    ex = model(8'h5A, 1'b0, 4, 0);
    s_valid = 1'b1; s_data = 8'h5A; s_row = 4'd4; s_col = 9'd0;
    @(negedge clk);
    s_data = 8'hC3; s_col = 9'd1;
    for (int k = 0; k < 3; k++) begin
      chk("R2 stalled ready", {8'h0, s_ready}, 9'h0);
      chk("R2 held data", {1'b0, m_data}, {1'b0, ex});
      chk("R2 held valid", {8'h0, m_valid}, 9'h1);
      @(negedge clk);
    end
    ey = model(8'hC3, 1'b0, 4, 1);
    m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk("R2 resume data R6", {1'b0, m_data}, {1'b0, ey});

    // R7 round trip
    for (int c = 0; c < 12; c++) begin
      orig[c] = 8'(c * 29 + 7);
      send(orig[c], c == 0, 0, c + 2, "R7 pass1");
      scr[c] = last_out;
    end
    for (int c = 0; c < 12; c++) begin
      send(scr[c], c == 0, 0, c + 2, "R7 pass2");
      chk("R7 restored", {1'b0, last_out}, {1'b0, orig[c]});
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule